// File: doc/BRIEF.md
# Access-Point Beacon Timer Generator

This block keeps a free-running microsecond time-synchronisation counter (TSF) and three periodic event timers that follow it: the target beacon transmission time (TBTT), an alert that lets beacon DMA start ahead of TBTT, and an earlier alert that lets software prepare the beacon. Each timer raises a one-cycle strobe when the counter reaches its target. It then moves its target forward by one beacon period.

Software programs the block through a simple write port. It first sets the two lead times (in microseconds) and the period. The period is given as a count of 1/8-TU units plus a microsecond remainder, which makes up for precision lost when converting units. Software then writes the next beacon time, again in 1/8 TU. That single write loads all three targets: TBTT, TBTT minus the DMA lead, and TBTT minus the software lead. A mode word enables each timer on its own and drives an ad-hoc transmit policy output. A flag in the period write clears the counter.

Top module: `beacon_timer_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tsf` becomes 0, all three strobes become 0 and `adhoc_policy` becomes 0.
- R2: `tsf` increases by exactly 1 at each clock edge where `us_tick` is high, and holds its value where `us_tick` is low (unless R9 applies).
- R3: A write of N to address 0 sets the TBTT target to N shifted left by 7 (N × 128 µs). With mode bit 0 set, `tbtt_strobe` is high for the one cycle after the cycle in which `tsf` equals that target.
- R4: The DMA alert target is N×128 minus the value last written to address 1. `dma_alert_strobe` follows the R3 timing when mode bit 1 is set.
- R5: The software alert target is N×128 minus the value last written to address 2. `sw_alert_strobe` follows the R3 timing when mode bit 2 is set.
- R6: The period is (bits 15:0 of address 3) × 128 plus bits 15:0 of address 4. All three timers share it. After each firing, a timer's next firing comes exactly one period later.
- R7: With `us_tick` high every cycle and a period above 1, each strobe lasts exactly one cycle.
- R8: A timer whose mode bit is 0 produces no strobe.
- R9: A write to address 3 with bit 31 set makes `tsf` equal 0 after that clock edge.
- R10: Bit 3 of the mode word at address 5 drives `adhoc_policy`.
- R11: A write to address 0 replaces the pending targets from the next cycle on, even while the timers are enabled. A target that lies behind `tsf` produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-microsecond advance enable for the TSF |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 next beacon, 1 DMA lead, 2 SW lead, 3 period, 4 fraction, 5 mode) |
| wr_data | input | W | Register write data |
| tsf | output | W | Current TSF value in microseconds |
| tbtt_strobe | output | 1 | TBTT event, one cycle |
| dma_alert_strobe | output | 1 | DMA beacon alert event, one cycle |
| sw_alert_strobe | output | 1 | Software beacon alert event, one cycle |
| adhoc_policy | output | 1 | Ad-hoc beacon/ATIM transmit policy bit |

## Verification
Every cycle, the assertions check the reset state, the TSF stepping and holding rules, the TSF clear, and that a disabled timer stays silent. Only the bench scenarios can show the arithmetic: that each strobe lands on the computed TBTT or lead-offset time, that re-arming adds exactly the shared period including the fraction, and that a reload moves the pending event or drops one already in the past.

// File: rtl/bt_pkg.sv
// Shared definitions for the beacon timer generator.
// Assumes a three-bit register address space and three timers.
package bt_pkg;
    localparam int NUM_TIMERS = 3;
    localparam int TMR_TBTT   = 0;
    localparam int TMR_DMA    = 1;
    localparam int TMR_SW     = 2;

    localparam int ADDR_W         = 3;
    localparam int MODE_ADHOC_BIT = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_NEXT     = 3'd0,
        REG_DMA_LEAD = 3'd1,
        REG_SW_LEAD  = 3'd2,
        REG_PERIOD   = 3'd3,
        REG_FRAC     = 3'd4,
        REG_MODE     = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/bt_regs.sv
// Configuration registers and target derivation.
// A write to REG_NEXT yields a one-cycle load with three targets:
// TBTT and TBTT minus each lead. The period is the shifted
// 1/8-TU count plus the microsecond fraction.
// Assumes W is wide enough to hold the shifted values.
module bt_regs
    import bt_pkg::*;
#(
    parameter int W         = 32,
    parameter int PER_W     = 16,
    parameter int FRAC_W    = 16,
    parameter int TU8_SHIFT = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [W-1:0]                    wr_data,
    output logic [W-1:0]                    period,
    output logic [NUM_TIMERS-1:0]           enable,
    output logic                            adhoc,
    output logic                            load,
    output logic [NUM_TIMERS-1:0][W-1:0]    load_val,
    output logic                            tsf_clear
);
    localparam int CLR_BIT = W - 1;

    logic [W-1:0]      dma_lead;
    logic [W-1:0]      sw_lead;
    logic [PER_W-1:0]  per_tu8;
    logic [FRAC_W-1:0] frac;
    logic [W-1:0]      base;

    // Register storage updated by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_lead <= '0;
            sw_lead  <= '0;
            per_tu8  <= '0;
            frac     <= '0;
            enable   <= '0;
            adhoc    <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_DMA_LEAD: dma_lead <= wr_data;
                REG_SW_LEAD:  sw_lead  <= wr_data;
                REG_PERIOD:   per_tu8  <= wr_data[PER_W-1:0];
                REG_FRAC:     frac     <= wr_data[FRAC_W-1:0];
                REG_MODE: begin
                    enable <= wr_data[NUM_TIMERS-1:0];
                    adhoc  <= wr_data[MODE_ADHOC_BIT];
                end
                default: ;
            endcase
        end
    end

    // Shared period in microseconds.
    always_comb begin
        period = (W'(per_tu8) << TU8_SHIFT) + W'(frac);
    end

    // Target load and TSF clear decoded straight from the write.
    always_comb begin
        base                = wr_data << TU8_SHIFT;
        load                = wr_en && (reg_addr_e'(wr_addr) == REG_NEXT);
        load_val[TMR_TBTT]  = base;
        load_val[TMR_DMA]   = base - dma_lead;
        load_val[TMR_SW]    = base - sw_lead;
        tsf_clear           = wr_en && (reg_addr_e'(wr_addr) == REG_PERIOD)
                              && wr_data[CLR_BIT];
    end
endmodule

// File: rtl/bt_tsf.sv
// Free-running TSF counter in microseconds.
// Advances on us_tick; a clear request wins over the advance.
module bt_tsf #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         us_tick,
    input  logic         clear,
    output logic [W-1:0] tsf
);
    // Count, clear or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tsf <= '0;
        end else if (us_tick) begin
            tsf <= tsf + 1'b1;
        end
    end
endmodule

// File: rtl/bt_slot.sv
// One periodic event timer.
// Fires when enabled and TSF equals the target: the strobe is
// registered, so it rises one cycle later. The target then advances
// by the period. A load replaces the target and takes priority.
// Assumes TSF advances by at most 1 per cycle, so equality is never skipped.
module bt_slot #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tsf,
    input  logic         enable,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] period,
    output logic         strobe
);
    logic [W-1:0] target;
    logic         hit;

    // Expiry comparison.
    always_comb begin
        hit = enable && (tsf == target);
    end

    // Strobe register and target re-arm or reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= hit;
            if (load) begin
                target <= load_val;
            end else if (hit) begin
                target <= target + period;
            end
        end
    end
endmodule

// File: rtl/beacon_timer_gen.sv
// Top of the beacon timer generator: register block, TSF counter
// and one timer slot per event, generated from the package count.
// Assumes writes come from a single synchronous agent.
module beacon_timer_gen
    import bt_pkg::*;
#(
    parameter int W         = 32,
    parameter int PER_W     = 16,
    parameter int FRAC_W    = 16,
    parameter int TU8_SHIFT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [W-1:0]      tsf,
    output logic              tbtt_strobe,
    output logic              dma_alert_strobe,
    output logic              sw_alert_strobe,
    output logic              adhoc_policy
);
    logic [W-1:0]                   period;
    logic [NUM_TIMERS-1:0]          enable;
    logic                           load;
    logic [NUM_TIMERS-1:0][W-1:0]   load_val;
    logic                           tsf_clear;
    logic [NUM_TIMERS-1:0]          strobe;

    bt_regs #(
        .W(W), .PER_W(PER_W), .FRAC_W(FRAC_W), .TU8_SHIFT(TU8_SHIFT)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .period    (period),
        .enable    (enable),
        .adhoc     (adhoc_policy),
        .load      (load),
        .load_val  (load_val),
        .tsf_clear (tsf_clear)
    );

    bt_tsf #(.W(W)) i_tsf (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .clear   (tsf_clear),
        .tsf     (tsf)
    );

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_slot
        bt_slot #(.W(W)) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .tsf      (tsf),
            .enable   (enable[i]),
            .load     (load),
            .load_val (load_val[i]),
            .period   (period),
            .strobe   (strobe[i])
        );
    end

    // Map the strobe vector onto named outputs.
    always_comb begin
        tbtt_strobe      = strobe[TMR_TBTT];
        dma_alert_strobe = strobe[TMR_DMA];
        sw_alert_strobe  = strobe[TMR_SW];
    end
endmodule

// File: rtl/bt_checker.sv
// Property checker for beacon_timer_gen, attached by bind.
// Watches the TSF stepping rules, the clear, the reset state and
// the silence of disabled timers.
module bt_checker #(
    parameter int W = 32,
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         us_tick,
    input logic         tsf_clear,
    input logic [W-1:0] tsf,
    input logic [N-1:0] enable,
    input logic [N-1:0] strobe
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (strobe == '0 && tsf == '0));

    p_tsf_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (us_tick && !tsf_clear) |=> (tsf == $past(tsf) + 1'b1));

    p_tsf_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!us_tick && !tsf_clear) |=> $stable(tsf));

    p_tsf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tsf_clear |=> (tsf == '0));

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !enable[i] |=> !strobe[i]);
    end
endmodule

bind beacon_timer_gen bt_checker #(.W(W), .N(bt_pkg::NUM_TIMERS)) i_bt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .us_tick   (us_tick),
    .tsf_clear (tsf_clear),
    .tsf       (tsf),
    .enable    (enable),
    .strobe    (strobe)
);

// File: tb/test_beacon_timer_gen.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected TSF times per timer,
// the monitor pops one on every strobe and compares.
module test_beacon_timer_gen;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         us_tick = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] tsf;
    logic         tbtt_strobe, dma_alert_strobe, sw_alert_strobe, adhoc_policy;

    int n_chk = 0;
    int n_fail = 0;
    longint q_exp0[$];
    longint q_exp1[$];
    longint q_exp2[$];
    logic [2:0] prev_s = '0;
    int fired [3] = '{0, 0, 0};

    beacon_timer_gen i_beacon_timer_gen (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tsf(tsf), .tbtt_strobe(tbtt_strobe),
        .dma_alert_strobe(dma_alert_strobe), .sw_alert_strobe(sw_alert_strobe),
        .adhoc_policy(adhoc_policy)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tsf(input longint v);
        while (longint'(tsf) != v) @(negedge clk);
    endtask

    task automatic pop_check(input int idx, input logic was_high);
        longint e;
        string tag;
        bit empty;
        tag = (idx == 0) ? "R3 R6" : (idx == 1) ? "R4 R6" : "R5 R6";
        chk(!was_high, "R7 strobe longer than one cycle", 1, 0);
        empty = (idx == 0) ? (q_exp0.size() == 0) :
                (idx == 1) ? (q_exp1.size() == 0) : (q_exp2.size() == 0);
        if (empty) begin
            chk(1'b0, "R8 R11 unexpected strobe", longint'(tsf) - 1, -1);
        end else begin
            if (idx == 0) e = q_exp0.pop_front();
            else if (idx == 1) e = q_exp1.pop_front();
            else e = q_exp2.pop_front();
            chk(longint'(tsf) - 1 == e, tag, longint'(tsf) - 1, e);
        end
        fired[idx]++;
    endtask

    // Monitor: compare every strobe with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tbtt_strobe)      pop_check(0, prev_s[0]);
            if (dma_alert_strobe) pop_check(1, prev_s[1]);
            if (sw_alert_strobe)  pop_check(2, prev_s[2]);
        end
        prev_s = {sw_alert_strobe, dma_alert_strobe, tbtt_strobe};
    end

    // Watchdog.
    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        longint t;
        repeat (3) @(negedge clk);
        chk(tsf == 0, "R1 tsf in reset", tsf, 0);
        chk({tbtt_strobe, dma_alert_strobe, sw_alert_strobe} == 3'b000,
            "R1 strobes in reset", {tbtt_strobe, dma_alert_strobe, sw_alert_strobe}, 0);
        chk(adhoc_policy == 1'b0, "R1 adhoc in reset", adhoc_policy, 0);
        rst_n = 1'b1;

        // Scenario A: all three timers, period 2*128+7 = 263.
        for (int k = 0; k < 4; k++) begin
            q_exp0.push_back(512 + k * 263);
            q_exp1.push_back(472 + k * 263);
            q_exp2.push_back(412 + k * 263);
        end
        wr(3'd1, 40);
        wr(3'd2, 100);
        wr(3'd3, 2);
        wr(3'd4, 7);
        wr(3'd0, 4);
        wr(3'd5, 32'h7);
        wait_tsf(1320);
        wr(3'd5, 32'h0);
        chk(q_exp0.size() == 0, "R3 R6 tbtt events missing", q_exp0.size(), 0);
        chk(q_exp1.size() == 0, "R4 R6 dma events missing", q_exp1.size(), 0);
        chk(q_exp2.size() == 0, "R5 R6 sw events missing", q_exp2.size(), 0);

        // Scenario B: timers off, TSF stepping and holding.
        repeat (100) @(negedge clk);
        t = tsf;
        @(negedge clk);
        chk(longint'(tsf) == t + 1, "R2 tsf step", tsf, t + 1);
        us_tick = 1'b0;
        t = tsf;
        repeat (5) @(negedge clk);
        chk(longint'(tsf) == t, "R2 tsf hold", tsf, t);
        us_tick = 1'b1;
        repeat (500) @(negedge clk);

        // Scenario C: TSF clear with the period write, period 128.
        wr(3'd4, 0);
        wr(3'd3, 32'h8000_0001);
        chk(tsf == 0, "R9 tsf clear", tsf, 0);

        // Scenario D: TBTT only, reload ahead, then reload into the past.
        q_exp0.push_back(128);
        q_exp0.push_back(256);
        wr(3'd0, 1);
        wr(3'd5, 32'h9);
        chk(adhoc_policy == 1'b1, "R10 adhoc policy", adhoc_policy, 1);
        wait_tsf(300);
        q_exp0.push_back(640);
        q_exp0.push_back(768);
        wr(3'd0, 5);
        wait_tsf(800);
        wr(3'd0, 2);
        repeat (400) @(negedge clk);
        chk(q_exp0.size() == 0, "R11 reload events missing", q_exp0.size(), 0);
        chk(fired[0] == 8, "R3 R11 tbtt count", fired[0], 8);
        chk(fired[1] == 4, "R4 R8 dma count", fired[1], 4);
        chk(fired[2] == 4, "R5 R8 sw count", fired[2], 4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule